// File: doc/BRIEF.md
# Mailbox Time-Stamp and Time-Out Unit

This block keeps a free-running time-stamp counter for a message controller with a set of mailboxes. The counter advances by one on every pulse of a bit-time tick, so its value is a time base in bus bit times. When the protocol side reports that a mailbox has finished a transmit or a receive, the counter value from that cycle is stored in the time stamp of that mailbox. A read port returns any stored time stamp.

Each mailbox also has a time-out limit and a time-out enable bit. Writing a limit arms the mailbox. An armed and enabled mailbox that has not finished by the time the counter equals its limit gets its time-out status bit set. The bit stays set until the CPU clears it. Status updates go through an update port with a fixed priority. Protocol completions always take that port first. Time-outs waiting for the port are posted one per cycle, in mailbox order. A global time-out output and a sticky counter-overflow flag complete the outputs.

Top module: `mbt_timestamp_unit`

## Requirements
- R1: After reset the counter is 0. It rises by exactly one on each clock edge where `bit_tick` is 1, goes from all ones to 0, and holds its value on every other edge.
- R2: When `comp_valid` is 1, the counter value of that cycle is stored in the time stamp of mailbox `comp_idx`. `rd_stamp` returns the time stamp of mailbox `rd_idx` from the next cycle on.
- R3: A mailbox times out when three things hold: it is armed, its enable bit is set, and the counter equals its limit. The mailbox is armed by a write to its limit. The time-out is detected in the cycle in which the counter shows the limit. The status bit is set two clock edges after the counter reaches that value, provided no completion occupies the update port.
- R4: A disabled mailbox never times out. Neither does a mailbox that has completed since its limit was last written.
- R5: A completion for a mailbox cancels its time-out. This holds when the completion falls in the detection cycle and also when the time-out is still waiting for the update port. In both cases the status bit is not set.
- R6: While `comp_valid` is 1, no time-out status bit is set. Pending time-outs are posted once the port is free, one per cycle, lowest mailbox index first.
- R7: CPU writes use `cpu_sel` = 0 for a limit (`cpu_idx`, all of `cpu_wdata`), 1 for the enable vector (bit n of `cpu_wdata` is mailbox n), 2 for status and 3 for the overflow flag. Writing `cpu_sel` = 2 clears each status bit whose data bit is 1 and leaves bits written 0 untouched. A status bit that is set and cleared in the same cycle ends up set.
- R8: `to_any` is 1 exactly when at least one time-out status bit is 1.
- R9: A counter step from all ones to 0 sets `ovf_flag`. Writing `cpu_sel` = 3 with data bit 0 equal to 1 clears the flag, but a wrap in the same cycle keeps it set.
- R10: Reset clears the counter, all status bits, `to_any`, `ovf_flag`, all time stamps, the enable vector and the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One pulse per bus bit time |
| comp_valid | input | 1 | Mailbox completed a transmit or receive |
| comp_idx | input | IDX_W | Index of the completing mailbox |
| cpu_we | input | 1 | CPU write strobe |
| cpu_sel | input | 2 | CPU target: 0 limit, 1 enable, 2 status clear, 3 overflow clear |
| cpu_idx | input | IDX_W | Mailbox index for a limit write |
| cpu_wdata | input | CNT_W | CPU write data |
| rd_idx | input | IDX_W | Mailbox whose time stamp is read |
| rd_stamp | output | CNT_W | Time stamp of mailbox `rd_idx` |
| ts_count | output | CNT_W | Current counter value |
| to_status | output | NUM_MB | Per-mailbox time-out status |
| to_any | output | 1 | Global time-out flag |
| ovf_flag | output | 1 | Counter overflow flag |

## Verification
The bench builds the unit with four mailboxes and an 8-bit counter. With these values a counter wrap takes only 256 ticks, so the overflow flag is reached during the random phase. A second wrap is then timed to land exactly on an overflow clear. Four mailboxes are enough for two time-outs to wait on the update port at the same time, which exposes the posting order. A small counter also makes time-out limits cheap to reach. This allows directed cases where a completion lands in the detection cycle or in the waiting cycle, and one where a status clear meets a new time-out.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

   // CPU write targets
   typedef enum logic [1:0] {
      SEL_LIMIT  = 2'd0,
      SEL_ENABLE = 2'd1,
      SEL_STATUS = 2'd2,
      SEL_OVF    = 2'd3
   } mbt_sel_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mbt_tick_counter.sv
module mbt_tick_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] count_q;
   logic             ovf_q;
   logic             wrap;

   assign wrap = tick && (count_q == ALL_ONES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
         ovf_q   <= 1'b0;
      end else begin
         if (tick) begin
            count_q <= count_q + CNT_W'(1);
         end
         // a wrap in the clearing cycle keeps the flag set
         ovf_q <= (ovf_q && !ovf_clr) || wrap;
      end
   end

   assign count = count_q;
   assign ovf   = ovf_q;

   // R1: the counter only moves on a tick
   p_count_moves_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(count_q) |-> $past(tick));

   // R9: the flag only rises after a step out of all ones
   p_ovf_needs_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_q) |-> ($past(tick) && ($past(count_q) == ALL_ONES)));

endmodule

// File: rtl/mbt_timeout_detect.sv
module mbt_timeout_detect #(
   parameter int NUM_MB = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  count,
   input  logic [CNT_W-1:0]  limit [NUM_MB],
   input  logic [NUM_MB-1:0] enable,
   input  logic [NUM_MB-1:0] arm_set,
   input  logic [NUM_MB-1:0] done,
   input  logic [NUM_MB-1:0] grant,
   output logic [NUM_MB-1:0] hit
);

   for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
      logic armed_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            armed_q <= 1'b0;
         end else if (arm_set[g]) begin
            armed_q <= 1'b1;
         end else if (done[g] || grant[g]) begin
            armed_q <= 1'b0;
         end
      end

      // a completion in the detection cycle suppresses the hit
      assign hit[g] = armed_q && enable[g] && !done[g] && (count == limit[g]);

      // R4: a completed mailbox cannot hit on the next cycle
      p_done_disarms_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (done[g] && !arm_set[g]) |=> !hit[g]);
   end

endmodule

// File: rtl/mbt_update_arb.sv
module mbt_update_arb #(
   parameter int NUM_MB    = 32,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_MB-1:0] hit,
   input  logic [NUM_MB-1:0] done,
   input  logic              proto_busy,
   input  logic [NUM_MB-1:0] clr,
   output logic [NUM_MB-1:0] grant,
   output logic [NUM_MB-1:0] status
);

   logic [NUM_MB-1:0] pend_q;
   logic [NUM_MB-1:0] status_q;
   logic [NUM_MB-1:0] pick;

   if (LOW_FIRST) begin : g_low_first
      always_comb begin
         pick = '0;
         for (int i = NUM_MB - 1; i >= 0; i--) begin
            if (pend_q[i]) begin
               pick    = '0;
               pick[i] = 1'b1;
            end
         end
      end
   end else begin : g_high_first
      always_comb begin
         pick = '0;
         for (int i = 0; i < NUM_MB; i++) begin
            if (pend_q[i]) begin
               pick    = '0;
               pick[i] = 1'b1;
            end
         end
      end
   end

   // the protocol side owns the update port whenever it asks
   assign grant = proto_busy ? '0 : pick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q   <= '0;
         status_q <= '0;
      end else begin
         pend_q   <= (pend_q | hit) & ~done & ~grant;
         status_q <= (status_q & ~clr) | grant;
      end
   end

   assign status = status_q;

   // R6: at most one time-out posted per cycle
   p_grant_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6: no status bit rises across a cycle owned by the protocol side
   p_busy_defers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      proto_busy |=> ((status_q & ~$past(status_q)) == '0));

   // R3: a status bit only rises for a time-out that was waiting
   p_rise_from_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~$past(status_q) & ~$past(pend_q)) == '0));

endmodule

// File: rtl/mbt_timestamp_unit.sv
module mbt_timestamp_unit #(
   parameter int NUM_MB    = 32,
   parameter int CNT_W     = 32,
   parameter bit LOW_FIRST = 1'b1,
   localparam int IDX_W    = mbt_pkg::idx_width(NUM_MB)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              comp_valid,
   input  logic [IDX_W-1:0]  comp_idx,
   input  logic              cpu_we,
   input  logic [1:0]        cpu_sel,
   input  logic [IDX_W-1:0]  cpu_idx,
   input  logic [CNT_W-1:0]  cpu_wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [CNT_W-1:0]  rd_stamp,
   output logic [CNT_W-1:0]  ts_count,
   output logic [NUM_MB-1:0] to_status,
   output logic              to_any,
   output logic              ovf_flag
);

   import mbt_pkg::*;

   if (NUM_MB < 2 || NUM_MB > CNT_W) begin : g_bad_num_mb
      $error("NUM_MB must lie between 2 and CNT_W");
   end
   if (CNT_W < 4) begin : g_bad_cnt_w
      $error("CNT_W must be at least 4");
   end

   mbt_sel_e sel;
   assign sel = mbt_sel_e'(cpu_sel);

   logic [CNT_W-1:0]  count;
   logic [CNT_W-1:0]  limit_q [NUM_MB];
   logic [CNT_W-1:0]  stamp_q [NUM_MB];
   logic [NUM_MB-1:0] en_q;
   logic [NUM_MB-1:0] done;
   logic [NUM_MB-1:0] arm_set;
   logic [NUM_MB-1:0] hit;
   logic [NUM_MB-1:0] grant;
   logic [NUM_MB-1:0] status_clr;
   logic              ovf_clr;

   assign done       = comp_valid ? (NUM_MB'(1) << comp_idx) : '0;
   assign arm_set    = (cpu_we && sel == SEL_LIMIT) ? (NUM_MB'(1) << cpu_idx) : '0;
   assign status_clr = (cpu_we && sel == SEL_STATUS) ? cpu_wdata[NUM_MB-1:0] : '0;
   assign ovf_clr    = cpu_we && (sel == SEL_OVF) && cpu_wdata[0];

   mbt_tick_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_tick),
      .ovf_clr (ovf_clr),
      .count   (count),
      .ovf     (ovf_flag)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         for (int i = 0; i < NUM_MB; i++) begin
            limit_q[i] <= '0;
            stamp_q[i] <= '0;
         end
      end else begin
         if (cpu_we && sel == SEL_ENABLE) begin
            en_q <= cpu_wdata[NUM_MB-1:0];
         end
         if (cpu_we && sel == SEL_LIMIT && int'(cpu_idx) < NUM_MB) begin
            limit_q[cpu_idx] <= cpu_wdata;
         end
         if (comp_valid && int'(comp_idx) < NUM_MB) begin
            stamp_q[comp_idx] <= count;
         end
      end
   end

   mbt_timeout_detect #(.NUM_MB(NUM_MB), .CNT_W(CNT_W)) u_detect (
      .clk     (clk),
      .rst_n   (rst_n),
      .count   (count),
      .limit   (limit_q),
      .enable  (en_q),
      .arm_set (arm_set),
      .done    (done),
      .grant   (grant),
      .hit     (hit)
   );

   mbt_update_arb #(.NUM_MB(NUM_MB), .LOW_FIRST(LOW_FIRST)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .hit        (hit),
      .done       (done),
      .proto_busy (comp_valid),
      .clr        (status_clr),
      .grant      (grant),
      .status     (to_status)
   );

   assign to_any   = |to_status;
   assign ts_count = count;
   assign rd_stamp = stamp_q[rd_idx];

   // R2: the stamp holds the counter value of the completion cycle
   p_stamp_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      comp_valid |=> (stamp_q[$past(comp_idx)] == $past(count)));

   // R5: a completion never lets its own status bit rise
   p_comp_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      comp_valid |=> !(to_status[$past(comp_idx)] && !$past(to_status[comp_idx])));

endmodule

// File: tb/mbt_timestamp_unit_tb.sv
module mbt_timestamp_unit_tb;

   localparam int NMB   = 4;
   localparam int CW    = 8;
   localparam int IW    = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0;
   logic          comp_valid = 1'b0;
   logic [IW-1:0] comp_idx = '0;
   logic          cpu_we = 1'b0;
   logic [1:0]    cpu_sel = '0;
   logic [IW-1:0] cpu_idx = '0;
   logic [CW-1:0] cpu_wdata = '0;
   logic [IW-1:0] rd_idx = '0;
   logic [CW-1:0] rd_stamp;
   logic [CW-1:0] ts_count;
   logic [NMB-1:0] to_status;
   logic          to_any;
   logic          ovf_flag;

   int n_chk  = 0;
   int n_fail = 0;

   logic [CW-1:0] m_cnt = '0;
   logic [CW-1:0] m_stamp [NMB];
   logic          m_ovf = 1'b0;

   always #10 clk = ~clk;

   mbt_timestamp_unit #(.NUM_MB(NMB), .CNT_W(CW), .LOW_FIRST(1'b1)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_tick   (bit_tick),
      .comp_valid (comp_valid),
      .comp_idx   (comp_idx),
      .cpu_we     (cpu_we),
      .cpu_sel    (cpu_sel),
      .cpu_idx    (cpu_idx),
      .cpu_wdata  (cpu_wdata),
      .rd_idx     (rd_idx),
      .rd_stamp   (rd_stamp),
      .ts_count   (ts_count),
      .to_status  (to_status),
      .to_any     (to_any),
      .ovf_flag   (ovf_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one clock edge; inputs change and outputs are sampled at the falling edge
   task automatic step();
      if (comp_valid && comp_idx < NMB) m_stamp[comp_idx] = m_cnt;
      if (bit_tick) begin
         if (m_cnt == {CW{1'b1}}) m_ovf = 1'b1;
         m_cnt = m_cnt + 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic run(input int n, input logic tk);
      bit_tick = tk;
      for (int i = 0; i < n; i++) step();
      bit_tick = 1'b0;
   endtask

   task automatic cpu_write(input logic [1:0] s, input logic [IW-1:0] idx, input logic [CW-1:0] d);
      cpu_we = 1'b1; cpu_sel = s; cpu_idx = idx; cpu_wdata = d;
      step();
      cpu_we = 1'b0;
   endtask

   task automatic complete(input logic [IW-1:0] idx);
      comp_valid = 1'b1; comp_idx = idx;
      step();
      comp_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [CW-1:0] lim;
      void'($urandom(32'd4711));
      for (int i = 0; i < NMB; i++) m_stamp[i] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 count", ts_count, 0);
      chk("R10 status", to_status, 0);
      chk("R10 any", to_any, 0);
      chk("R10 ovf", ovf_flag, 0);
      chk("R10 stamp", rd_stamp, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // random phase: counter, stamps and overflow against the model
      for (int c = 0; c < 700; c++) begin
         bit_tick   = 1'($urandom % 2);
         comp_valid = (($urandom % 4) == 0);
         comp_idx   = IW'($urandom % NMB);
         step();
         rd_idx = IW'($urandom % NMB);
         #1;
         chk("R1 count", ts_count, m_cnt);
         chk("R2 stamp", rd_stamp, m_stamp[rd_idx]);
         chk("R9 ovf", ovf_flag, m_ovf);
         chk("R4 no timeout while disabled", to_status, 0);
      end
      bit_tick = 1'b0; comp_valid = 1'b0;
      chk("R9 wrap seen", m_ovf, 1);
      cpu_write(2'd3, '0, 8'h00);
      chk("R9 write 0 keeps flag", ovf_flag, 1);
      cpu_write(2'd3, '0, 8'h01);
      chk("R9 clear", ovf_flag, 0);

      // R3: basic time-out with exact latency
      cpu_write(2'd1, '0, 8'h0F);
      lim = m_cnt + 8'd5;
      cpu_write(2'd0, 2'd0, lim);
      run(5, 1'b1);
      chk("R1 count at limit", ts_count, lim);
      chk("R3 not yet", to_status, 0);
      run(1, 1'b0);
      chk("R3 still waiting", to_status, 0);
      run(1, 1'b0);
      chk("R3 set", to_status, 4'b0001);
      chk("R8 any set", to_any, 1);

      // R7: write-one-to-clear
      cpu_write(2'd2, '0, 8'h00);
      chk("R7 write 0 no effect", to_status, 4'b0001);
      cpu_write(2'd2, '0, 8'h01);
      chk("R7 cleared", to_status, 0);
      chk("R8 any clear", to_any, 0);

      // R4: disabled mailbox 1 and completed mailbox 2 do not time out
      lim = m_cnt + 8'd4;
      cpu_write(2'd0, 2'd1, lim);
      cpu_write(2'd0, 2'd2, lim);
      cpu_write(2'd1, '0, 8'h0D);
      complete(2'd2);
      run(4, 1'b1);
      run(3, 1'b0);
      chk("R4 disabled or completed", to_status, 0);

      // R5: completion in the detection cycle
      cpu_write(2'd1, '0, 8'h09);
      cpu_write(2'd0, 2'd3, m_cnt + 8'd2);
      run(2, 1'b1);
      complete(2'd3);
      run(3, 1'b0);
      chk("R5 same-cycle completion", to_status, 0);

      // R5: completion while the time-out waits for the port
      cpu_write(2'd0, 2'd0, m_cnt + 8'd1);
      run(1, 1'b1);
      run(1, 1'b0);
      complete(2'd0);
      run(3, 1'b0);
      chk("R5 waiting time-out cancelled", to_status, 0);

      // R6: deferral while the protocol side owns the port, then lowest first
      cpu_write(2'd1, '0, 8'h0F);
      cpu_write(2'd0, 2'd0, m_cnt + 8'd1);
      cpu_write(2'd0, 2'd1, m_cnt + 8'd1);
      run(1, 1'b1);
      run(1, 1'b0);
      chk("R6 both waiting", to_status, 0);
      complete(2'd3);
      chk("R6 deferred by completion", to_status, 0);
      run(1, 1'b0);
      chk("R6 lowest first", to_status, 4'b0001);
      run(1, 1'b0);
      chk("R6 second posted", to_status, 4'b0011);

      // R7: set and clear in the same cycle leaves the bit set
      cpu_write(2'd0, 2'd2, m_cnt + 8'd1);
      run(1, 1'b1);
      run(1, 1'b0);
      cpu_write(2'd2, '0, 8'h07);
      chk("R7 set wins over clear", to_status, 4'b0100);
      chk("R8 any", to_any, 1);

      // R9: wrap in the clearing cycle keeps the flag set
      bit_tick = 1'b1;
      while (m_cnt != {CW{1'b1}}) step();
      cpu_we = 1'b1; cpu_sel = 2'd3; cpu_wdata = 8'h01;
      step();
      cpu_we = 1'b0; bit_tick = 1'b0;
      chk("R1 wrap to zero", ts_count, 0);
      chk("R9 wrap wins over clear", ovf_flag, 1);
      cpu_write(2'd3, '0, 8'h01);
      chk("R9 clear after wrap", ovf_flag, 0);
      chk("R4 disarmed mailboxes stay quiet", to_status, 4'b0100);

      finish_run();
   end

endmodule